// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of a variable-length byte-stream decoder. It receives instruction bytes one per cycle on a valid/ready input, always starting at an instruction boundary. Legacy prefix bytes are absorbed into a running summary, and so is an optional REX byte when 64-bit mode is selected. The first byte that is not a prefix ends the scan. That byte is presented together with the summary on a valid/ready output. The summary holds the segment override, the operand-size and address-size flags, lock, the repeat kind, the REX fields, the mandatory SIMD selector, a no-operation flag and the number of prefix bytes.

Back-pressure rules: `in_ready` is high only while the scan is in progress. From the cycle the summary is presented until it is accepted (`out_valid && out_ready` at a clock edge), `in_ready` is low, so an offered byte waits and is taken after the accept. While `out_valid` is high and `out_ready` is low, every summary field stays stable. The one exception is `out_fault`, which follows the `rest_len` side input. Accepting the summary clears all prefix state for the next instruction.

A downstream length decoder supplies `rest_len`, the number of bytes that follow the opcode byte. The block raises a length fault whenever prefixes plus opcode plus those remaining bytes exceed 15. If a fifteenth prefix byte arrives, the instruction cannot fit. The scan then stops at once and presents a faulting summary without waiting for an opcode.

Top module: `pfx_scanner`

## Requirements
- R1: Segment override bytes 0x26, 0x2E, 0x36, 0x3E, 0x64 and 0x65 set `out_seg_valid` and encode `out_seg` as 0, 1, 2, 3, 4 and 5 in that byte order. When several appear, the last one received is reported.
- R2: 0x66 sets `out_opsz` and 0x67 sets `out_adsz`. Further copies of either byte leave its flag set and never toggle it off.
- R3: 0xF0 sets `out_lock`. 0xF2 and 0xF3 set `out_rep` to 1 and 2 respectively (0 = none), and the last of them received is reported.
- R4: Prefixes are accepted in any order and in any number up to the length limit. `out_count` equals the number of prefix bytes consumed, REX bytes included.
- R5: `out_fault` is high while `out_valid` is high and `out_count` + 1 + `rest_len` exceeds 15, in the same cycle the sum first exceeds 15. A fifteenth prefix byte ends the scan immediately with `out_count` = 15 and `out_fault` high.
- R6: With `mode64` high, a byte 0x40..0x4F is a REX prefix whose low nibble (W,R,X,B from bit 3 down to bit 0) appears on `out_rex`, with `out_rex_valid` high. A legacy prefix received after it discards it, and a later REX byte replaces it.
- R7: With `mode64` low, a byte 0x40..0x4F is an opcode: it ends the scan with `out_rex_valid` low.
- R8: 0x0F ends the scan as an opcode byte. If the last legacy prefix before it is 0x66, 0xF3 or 0xF2, with only REX bytes in between, `out_simd` reports 1, 2 or 3 respectively. Otherwise `out_simd` is 0.
- R9: `out_nop` is high for opcode 0x90 unless a valid REX byte with bit 0 (B) set is present.
- R10: While a summary awaits acceptance, `in_ready` is low and the summary holds stable. After acceptance, the next instruction starts from a cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | Static mode select: 1 = 64-bit, 0 = 32-bit |
| in_valid | input | 1 | Instruction byte offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| rest_len | input | 4 | Bytes following the opcode, from the length decoder |
| out_valid | output | 1 | Summary and opcode presented |
| out_ready | input | 1 | Consumer accepts the summary |
| out_opcode | output | 8 | Byte that ended the scan |
| out_seg_valid | output | 1 | A segment override is present |
| out_seg | output | 3 | Selected segment code |
| out_opsz | output | 1 | Operand-size override |
| out_adsz | output | 1 | Address-size override |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | Repeat kind: 0 none, 1 not-equal, 2 equal |
| out_rex_valid | output | 1 | REX byte in effect |
| out_rex | output | 4 | REX W,R,X,B |
| out_simd | output | 2 | Mandatory selector: 0 none, 1 0x66, 2 0xF3, 3 0xF2 |
| out_nop | output | 1 | Opcode is a true no-operation |
| out_count | output | 4 | Prefix bytes consumed |
| out_fault | output | 1 | Instruction length exceeds 15 bytes |

## Verification
The hardest state to reach is the overflow, where fifteen prefix bytes must stream in back to back. Only then does the scan end on a prefix instead of an opcode. The stimulus drives exactly fourteen prefixes plus an opcode to confirm that the boundary does not fault. It then drives fifteen prefixes to confirm the early stop. The length check in the opcode case is reached by holding a summary under back-pressure and stepping `rest_len` across the limit, so the same held summary shows the fault flag switch. REX discard is covered by placing a legacy byte between a REX byte and the opcode.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [2:0] {
    K_OPC, K_SEG, K_OPSZ, K_ADSZ, K_LOCK, K_REPNE, K_REPE, K_REX
  } byte_kind_e;

  typedef struct packed {
    byte_kind_e kind;
    logic [2:0] seg;
  } byte_cls_t;

  localparam logic [1:0] REP_NONE = 2'd0;
  localparam logic [1:0] REP_NE   = 2'd1;
  localparam logic [1:0] REP_EQ   = 2'd2;

  localparam logic [1:0] SIMD_NONE = 2'd0;
  localparam logic [1:0] SIMD_66   = 2'd1;
  localparam logic [1:0] SIMD_F3   = 2'd2;
  localparam logic [1:0] SIMD_F2   = 2'd3;

  localparam logic [7:0] OPC_ESC = 8'h0F;
  localparam logic [7:0] OPC_NOP = 8'h90;

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic       mode64,
  input  logic [7:0] data,
  output byte_cls_t  cls
);

  always_comb begin
    cls.kind = K_OPC;
    cls.seg  = 3'd0;
    case (data)
      8'h26: begin cls.kind = K_SEG; cls.seg = 3'd0; end
      8'h2E: begin cls.kind = K_SEG; cls.seg = 3'd1; end
      8'h36: begin cls.kind = K_SEG; cls.seg = 3'd2; end
      8'h3E: begin cls.kind = K_SEG; cls.seg = 3'd3; end
      8'h64: begin cls.kind = K_SEG; cls.seg = 3'd4; end
      8'h65: begin cls.kind = K_SEG; cls.seg = 3'd5; end
      8'h66: cls.kind = K_OPSZ;
      8'h67: cls.kind = K_ADSZ;
      8'hF0: cls.kind = K_LOCK;
      8'hF2: cls.kind = K_REPNE;
      8'hF3: cls.kind = K_REPE;
      default: begin
        if (mode64 && data[7:4] == 4'h4) cls.kind = K_REX;
      end
    endcase
  end

endmodule

// File: rtl/pfx_state.sv
module pfx_state
  import pfx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode64,
  input  logic             apply,
  input  byte_cls_t        cls,
  input  logic [3:0]       rex_bits,
  input  logic             clear,
  output logic             seg_v,
  output logic [2:0]       seg,
  output logic             opsz,
  output logic             adsz,
  output logic             lock,
  output logic [1:0]       rep,
  output logic             rex_v,
  output logic [3:0]       rex,
  output logic [1:0]       simd_cand,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_v <= 1'b0; seg <= '0; opsz <= 1'b0; adsz <= 1'b0; lock <= 1'b0;
      rep <= REP_NONE; rex_v <= 1'b0; rex <= '0; simd_cand <= SIMD_NONE;
      count <= '0;
    end else if (clear) begin
      seg_v <= 1'b0; seg <= '0; opsz <= 1'b0; adsz <= 1'b0; lock <= 1'b0;
      rep <= REP_NONE; rex_v <= 1'b0; rex <= '0; simd_cand <= SIMD_NONE;
      count <= '0;
    end else if (apply) begin
      count <= count + 1'b1;
      if (cls.kind != K_REX) rex_v <= 1'b0;
      case (cls.kind)
        K_SEG:   begin seg_v <= 1'b1; seg <= cls.seg; simd_cand <= SIMD_NONE; end
        K_OPSZ:  begin opsz <= 1'b1; simd_cand <= SIMD_66; end
        K_ADSZ:  begin adsz <= 1'b1; simd_cand <= SIMD_NONE; end
        K_LOCK:  begin lock <= 1'b1; simd_cand <= SIMD_NONE; end
        K_REPNE: begin rep <= REP_NE; simd_cand <= SIMD_F2; end
        K_REPE:  begin rep <= REP_EQ; simd_cand <= SIMD_F3; end
        K_REX:   begin rex_v <= 1'b1; rex <= rex_bits; end
        default: ;
      endcase
    end
  end

  // R2: a size flag once set stays set until the summary is taken
  assert_opsz_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    opsz && !clear |=> opsz);
  assert_adsz_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adsz && !clear |=> adsz);
  // R6: REX state only exists in 64-bit mode
  assert_rex_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rex_v) |-> mode64);

endmodule

// File: rtl/pfx_len.sv
module pfx_len #(
  parameter int MAX_LEN = 15,
  parameter int CNT_W   = 4,
  parameter int REST_W  = 4
) (
  input  logic              hold,
  input  logic [CNT_W-1:0]  count,
  input  logic [REST_W-1:0] rest_len,
  output logic              fault
);

  localparam int SUM_W = ((CNT_W > REST_W) ? CNT_W : REST_W) + 2;

  logic [SUM_W-1:0] total;

  always_comb begin
    total = SUM_W'(count) + SUM_W'(rest_len) + SUM_W'(1);
    fault = hold && (total > SUM_W'(MAX_LEN));
  end

endmodule

// File: rtl/pfx_scanner.sv
module pfx_scanner
  import pfx_pkg::*;
#(
  parameter int MAX_LEN = 15,
  parameter int REST_W  = 4,
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode64,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic [REST_W-1:0] rest_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_opcode,
  output logic              out_seg_valid,
  output logic [2:0]        out_seg,
  output logic              out_opsz,
  output logic              out_adsz,
  output logic              out_lock,
  output logic [1:0]        out_rep,
  output logic              out_rex_valid,
  output logic [3:0]        out_rex,
  output logic [1:0]        out_simd,
  output logic              out_nop,
  output logic [CNT_W-1:0]  out_count,
  output logic              out_fault
);

  byte_cls_t  cls;
  logic       hold_q;
  logic [7:0] opc_q;
  logic       take, ends_scan, apply, clear;
  logic [1:0] simd_cand;

  pfx_classify u_cls (.mode64(mode64), .data(in_data), .cls(cls));

  assign take      = in_valid && !hold_q;
  assign ends_scan = (cls.kind == K_OPC) || (out_count == CNT_W'(MAX_LEN - 1));
  assign apply     = take && (cls.kind != K_OPC);
  assign clear     = hold_q && out_ready;

  pfx_state #(.CNT_W(CNT_W)) u_st (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .apply(apply), .cls(cls),
    .rex_bits(in_data[3:0]), .clear(clear),
    .seg_v(out_seg_valid), .seg(out_seg), .opsz(out_opsz), .adsz(out_adsz),
    .lock(out_lock), .rep(out_rep), .rex_v(out_rex_valid), .rex(out_rex),
    .simd_cand(simd_cand), .count(out_count)
  );

  pfx_len #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .REST_W(REST_W)) u_len (
    .hold(hold_q), .count(out_count), .rest_len(rest_len), .fault(out_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      opc_q  <= '0;
    end else if (clear) begin
      hold_q <= 1'b0;
    end else if (take && ends_scan) begin
      hold_q <= 1'b1;
      opc_q  <= in_data;
    end
  end

  assign in_ready   = !hold_q;
  assign out_valid  = hold_q;
  assign out_opcode = opc_q;
  assign out_simd   = (hold_q && opc_q == OPC_ESC) ? simd_cand : SIMD_NONE;
  assign out_nop    = hold_q && (opc_q == OPC_NOP) && !(out_rex_valid && out_rex[0]);

  // R10: no byte taken while a summary waits; summary stable under back-pressure
  assert_no_take_in_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_count)
      && $stable(out_seg) && $stable(out_rep) && $stable(out_rex_valid));
  // R5: a full prefix budget always reports a fault
  assert_full_count_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_count == CNT_W'(MAX_LEN) |-> out_fault);
  // R8: the selector only accompanies the two-byte escape
  assert_simd_on_escape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_simd != SIMD_NONE |-> out_valid && out_opcode == OPC_ESC);
  // R9: the register-8 exchange form is never a no-operation
  assert_nop_rexb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_nop |-> !(out_rex_valid && out_rex[0]));

endmodule

// File: tb/sim_pfx_scanner.sv
module sim_pfx_scanner;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode64 = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic [3:0] rest_len = 4'd0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_opcode;
  logic       out_seg_valid;
  logic [2:0] out_seg;
  logic       out_opsz, out_adsz, out_lock;
  logic [1:0] out_rep;
  logic       out_rex_valid;
  logic [3:0] out_rex;
  logic [1:0] out_simd;
  logic       out_nop;
  logic [3:0] out_count;
  logic       out_fault;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] seq[$];

  always #4 clk = ~clk;

  pfx_scanner u0 (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rest_len(rest_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_seg_valid(out_seg_valid), .out_seg(out_seg),
    .out_opsz(out_opsz), .out_adsz(out_adsz), .out_lock(out_lock), .out_rep(out_rep),
    .out_rex_valid(out_rex_valid), .out_rex(out_rex), .out_simd(out_simd),
    .out_nop(out_nop), .out_count(out_count), .out_fault(out_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send();
    foreach (seq[i]) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seq[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset out_valid", int'(out_valid), 0);
    chk("R10 reset in_ready", int'(in_ready), 1);
    chk("R5 reset fault", int'(out_fault), 0);
  endtask

  task automatic t_segment();
    mode64 = 1'b0;
    seq = '{8'h26, 8'h64, 8'h2E, 8'h8B};
    send();
    chk("R1 seg valid", int'(out_seg_valid), 1);
    chk("R1 seg last wins", int'(out_seg), 1);
    chk("R4 count", int'(out_count), 3);
    chk("R1 opcode", int'(out_opcode), 'h8B);
    accept();
    seq = '{8'h65, 8'h8B};
    send();
    chk("R1 seg gs", int'(out_seg), 5);
    accept();
  endtask

  task automatic t_sticky();
    seq = '{8'h66, 8'h67, 8'h66, 8'h67, 8'h67, 8'h89};
    send();
    chk("R2 opsz sticky", int'(out_opsz), 1);
    chk("R2 adsz sticky", int'(out_adsz), 1);
    chk("R4 count mixed", int'(out_count), 5);
    chk("R1 no seg", int'(out_seg_valid), 0);
    accept();
  endtask

  task automatic t_lock_rep();
    seq = '{8'hF0, 8'hF3, 8'hF2, 8'hA4};
    send();
    chk("R3 lock", int'(out_lock), 1);
    chk("R3 rep last ne", int'(out_rep), 1);
    accept();
    seq = '{8'hF2, 8'hF3, 8'hA5};
    send();
    chk("R3 rep last eq", int'(out_rep), 2);
    chk("R3 no lock", int'(out_lock), 0);
    accept();
  endtask

  task automatic t_rex();
    mode64 = 1'b1;
    seq = '{8'h48, 8'h01};
    send();
    chk("R6 rex valid", int'(out_rex_valid), 1);
    chk("R6 rex bits", int'(out_rex), 8);
    chk("R4 rex counted", int'(out_count), 1);
    accept();
    seq = '{8'h4C, 8'h66, 8'h01};
    send();
    chk("R6 rex discarded", int'(out_rex_valid), 0);
    chk("R6 opsz kept", int'(out_opsz), 1);
    chk("R4 count", int'(out_count), 2);
    accept();
    seq = '{8'h41, 8'h4A, 8'h01};
    send();
    chk("R6 later rex replaces", int'(out_rex), 'hA);
    accept();
    seq = '{8'h41, 8'h90};
    send();
    chk("R9 rex.b not nop", int'(out_nop), 0);
    accept();
    seq = '{8'h48, 8'h90};
    send();
    chk("R9 rex.w nop", int'(out_nop), 1);
    accept();
    seq = '{8'h90};
    send();
    chk("R9 plain nop", int'(out_nop), 1);
    accept();
  endtask

  task automatic t_mode32();
    mode64 = 1'b0;
    seq = '{8'h48};
    send();
    chk("R7 valid", int'(out_valid), 1);
    chk("R7 opcode", int'(out_opcode), 'h48);
    chk("R7 no rex", int'(out_rex_valid), 0);
    chk("R7 count", int'(out_count), 0);
    accept();
  endtask

  task automatic t_simd();
    seq = '{8'h66, 8'h0F};
    send();
    chk("R8 sel 66", int'(out_simd), 1);
    accept();
    seq = '{8'hF3, 8'hF2, 8'h0F};
    send();
    chk("R8 sel f2 last", int'(out_simd), 3);
    accept();
    mode64 = 1'b1;
    seq = '{8'hF2, 8'hF3, 8'h48, 8'h0F};
    send();
    chk("R8 sel f3 through rex", int'(out_simd), 2);
    chk("R6 rex kept", int'(out_rex_valid), 1);
    accept();
    mode64 = 1'b0;
    seq = '{8'h66, 8'h26, 8'h0F};
    send();
    chk("R8 seg breaks sel", int'(out_simd), 0);
    accept();
    seq = '{8'h66, 8'h8B};
    send();
    chk("R8 no escape", int'(out_simd), 0);
    accept();
  endtask

  task automatic t_length();
    seq = '{8'h66, 8'hC7};
    send();
    rest_len = 4'd13;
    #1;
    chk("R5 total 15 ok", int'(out_fault), 0);
    @(negedge clk);
    rest_len = 4'd14;
    #1;
    chk("R5 total 16 fault", int'(out_fault), 1);
    chk("R10 held", int'(out_valid), 1);
    rest_len = 4'd0;
    accept();
    seq = {};
    for (int i = 0; i < 14; i++) seq.push_back(8'h3E);
    seq.push_back(8'h8B);
    send();
    chk("R5 14 prefixes count", int'(out_count), 14);
    chk("R5 14 prefixes ok", int'(out_fault), 0);
    accept();
    seq = {};
    for (int i = 0; i < 15; i++) seq.push_back(8'h66);
    send();
    chk("R5 overflow stop", int'(out_valid), 1);
    chk("R5 overflow count", int'(out_count), 15);
    chk("R5 overflow fault", int'(out_fault), 1);
    accept();
  endtask

  task automatic t_backpressure();
    seq = '{8'h26, 8'h8B};
    send();
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h90;
    repeat (3) @(negedge clk);
    chk("R10 in_ready low", int'(in_ready), 0);
    chk("R10 opcode stable", int'(out_opcode), 'h8B);
    chk("R10 seg stable", int'(out_seg_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next taken", int'(out_valid), 1);
    chk("R10 next opcode", int'(out_opcode), 'h90);
    chk("R10 cleared seg", int'(out_seg_valid), 0);
    chk("R10 cleared count", int'(out_count), 0);
    accept();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_segment();
    t_sticky();
    t_lock_rep();
    t_rex();
    t_mode32();
    t_simd();
    t_length();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule